// File: doc/BRIEF.md
# Surround Disturb Memory Test Sequencer

This block is a built-in self-test engine for a bit-wide array of R rows and C columns. It checks whether a cell loses its contents when the opposite value is written into the cells directly above and below it. The engine visits every cell in turn. For each cell it runs a short fixed script of writes and reads on the cell, its left and right neighbours, and its upper and lower neighbours. When every cell has been visited, it repeats the whole walk with all data inverted.

The engine drives a synchronous single-port memory through a row address, a column address, an enable, a write strobe and one write-data bit. Read data comes back one cycle after the request. A pulse on `start` launches a run. `done` pulses once at the end of the run. `fail` rises on the first read that returns the wrong value, and stays high. The row, column and pass of that first failing read are kept for diagnosis. The memory must be laid out logically: row and column numbers are treated as physical neighbours.

Top module: `sd_surround_test`

## Requirements
- R1: After synchronous reset, `done`, `fail` and `mem_en` are low. No memory cycle is issued until `start` is sampled high.
- R2: For the cell at row p and column q, the script runs in this order:
  - write d to (p,q-1);
  - write d to (p,q);
  - write d to (p,q+1);
  - write ~d to (p-1,q);
  - read (p,q+1), expecting d;
  - write ~d to (p+1,q);
  - read (p,q-1), expecting d;
  - read (p,q), expecting d.
- R3: A script operation whose target lies outside the array uses no cycle. From the cycle after an accepted `start` until the final read, `mem_en` is high in every cycle and issues exactly one operation. After the final read, `mem_en` is low.
- R4: Cells are visited in row-major order: the column advances fastest, from row 0 column 0 to row R-1 column C-1.
- R5: In the first pass d is 0. In the second pass d is 1, so every written value and every expected value is inverted.
- R6: Read data is compared with the expected value in the cycle after the read request. A mismatch makes `fail` high two cycles after that request.
- R7: `fail` stays high once set. `fail_row` and `fail_col` hold the address of the first mismatching read, and `fail_pass` holds its pass (0 = true data, 1 = inverted data). These values are held until the next accepted start.
- R8: `done` is high for exactly one cycle, two cycles after the final read request of the second pass.
- R9: `start` is ignored while a run is in progress or a read compare is still pending. The operation sequence is not disturbed.
- R10: An accepted `start` clears `fail` and the captured failure fields. The cleared values are visible from the first operation cycle.
- R11: Every issued row address is below R and every column address is below C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches a run when idle |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Sticky mismatch flag |
| fail_pass | output | 1 | Pass of first mismatch (1 = inverted data) |
| fail_row | output | RW | Row of first mismatching read |
| fail_col | output | CW | Column of first mismatching read |
| mem_en | output | 1 | Memory operation request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_row | output | RW | Row address |
| mem_col | output | CW | Column address |
| mem_wdata | output | 1 | Write data bit |
| mem_rdata | input | 1 | Read data, valid one cycle after a read request |

## Verification
Runs on a 4×5 array are made against:
- a fault-free memory;
- stuck-at cells, with corners placed directly;
- vertical coupling faults, where a write to the cell above or below a victim forces the victim.

The fault-free run pins the complete operation stream. It shows the edge skipping, the visiting order and the inverted second pass with no fault interfering. A stuck-at-1 cell is caught in the first pass. A stuck-at-0 cell is caught only in the inverted pass, which tells the two passes apart in the captured pass bit. Coupling faults exercise the disturb reads themselves and check that the first failing address, not a later one, is kept. A start pulse during a run and a clean run after a failing one separate the ignore and clear rules.

// File: rtl/sd_pkg.sv
package sd_pkg;

    localparam int unsigned STEPS = 8;
    localparam int unsigned IDX_W = 3;

    // neighbour offset of a script operation along one axis
    typedef enum logic [1:0] {
        OFS_NONE = 2'd0,
        OFS_DEC  = 2'd1,
        OFS_INC  = 2'd2
    } offset_e;

    typedef struct packed {
        logic    is_write;
        logic    value;     // data for the true pass, before inversion
        offset_e drow;
        offset_e dcol;
    } step_t;

    // fixed eight-operation script applied to every cell
    function automatic step_t script_step(input logic [IDX_W-1:0] idx);
        step_t s;
        case (idx)
            3'd0:    s = '{is_write: 1'b1, value: 1'b0, drow: OFS_NONE, dcol: OFS_DEC};
            3'd1:    s = '{is_write: 1'b1, value: 1'b0, drow: OFS_NONE, dcol: OFS_NONE};
            3'd2:    s = '{is_write: 1'b1, value: 1'b0, drow: OFS_NONE, dcol: OFS_INC};
            3'd3:    s = '{is_write: 1'b1, value: 1'b1, drow: OFS_DEC,  dcol: OFS_NONE};
            3'd4:    s = '{is_write: 1'b0, value: 1'b0, drow: OFS_NONE, dcol: OFS_INC};
            3'd5:    s = '{is_write: 1'b1, value: 1'b1, drow: OFS_INC,  dcol: OFS_NONE};
            3'd6:    s = '{is_write: 1'b0, value: 1'b0, drow: OFS_NONE, dcol: OFS_DEC};
            default: s = '{is_write: 1'b0, value: 1'b0, drow: OFS_NONE, dcol: OFS_NONE};
        endcase
        return s;
    endfunction

    // the script always closes with this operation, which never leaves the array
    localparam logic [IDX_W-1:0] LAST_STEP = 3'd7;

endpackage

// File: rtl/sd_cursor.sv
module sd_cursor
    import sd_pkg::*;
#(
    parameter int unsigned ROWS = 16,
    parameter int unsigned COLS = 16,
    parameter int unsigned RW   = 4,
    parameter int unsigned CW   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_ok,
    input  logic [IDX_W-1:0] sel_idx,
    input  logic             sel_last,
    output logic             running,
    output logic             pass,
    output logic [RW-1:0]    cur_row,
    output logic [CW-1:0]    cur_col,
    output logic [IDX_W-1:0] op_idx,
    output logic             final_op
);

    localparam logic [RW-1:0] ROW_MAX = RW'(ROWS - 1);
    localparam logic [CW-1:0] COL_MAX = CW'(COLS - 1);

    logic row_end;
    logic col_end;

    assign row_end  = (cur_row == ROW_MAX);
    assign col_end  = (cur_col == COL_MAX);
    assign final_op = running & sel_last & row_end & col_end & pass;

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            pass    <= 1'b0;
            cur_row <= '0;
            cur_col <= '0;
            op_idx  <= '0;
        end else if (!running) begin
            if (start_ok) begin
                running <= 1'b1;
                pass    <= 1'b0;
                cur_row <= '0;
                cur_col <= '0;
                op_idx  <= '0;
            end
        end else if (sel_last) begin
            op_idx <= '0;
            if (col_end) begin
                cur_col <= '0;
                if (row_end) begin
                    cur_row <= '0;
                    if (pass) begin
                        running <= 1'b0;
                    end else begin
                        pass <= 1'b1;
                    end
                end else begin
                    cur_row <= cur_row + 1'b1;
                end
            end else begin
                cur_col <= cur_col + 1'b1;
            end
        end else begin
            op_idx <= sel_idx + 1'b1;
        end
    end

endmodule

// File: rtl/sd_step_picker.sv
module sd_step_picker
    import sd_pkg::*;
#(
    parameter int unsigned ROWS = 16,
    parameter int unsigned COLS = 16,
    parameter int unsigned RW   = 4,
    parameter int unsigned CW   = 4
) (
    input  logic [RW-1:0]    cur_row,
    input  logic [CW-1:0]    cur_col,
    input  logic [IDX_W-1:0] op_idx,
    input  logic             pass,
    output logic [IDX_W-1:0] sel_idx,
    output logic             sel_last,
    output logic [RW-1:0]    tgt_row,
    output logic [CW-1:0]    tgt_col,
    output logic             is_write,
    output logic             value
);

    localparam logic [RW-1:0] ROW_MAX = RW'(ROWS - 1);
    localparam logic [CW-1:0] COL_MAX = CW'(COLS - 1);

    logic [STEPS-1:0] in_array;

    // which script operations land inside the array for this cell
    for (genvar j = 0; j < STEPS; j++) begin : g_fit
        step_t s;
        logic  row_fits;
        logic  col_fits;
        assign s = script_step(IDX_W'(j));
        assign row_fits = (s.drow == OFS_DEC) ? (cur_row != '0) :
                          (s.drow == OFS_INC) ? (cur_row != ROW_MAX) : 1'b1;
        assign col_fits = (s.dcol == OFS_DEC) ? (cur_col != '0) :
                          (s.dcol == OFS_INC) ? (cur_col != COL_MAX) : 1'b1;
        assign in_array[j] = row_fits & col_fits;
    end

    // first operation at or after the cursor that fits
    always_comb begin
        logic found;
        found   = 1'b0;
        sel_idx = LAST_STEP;
        for (int j = 0; j < STEPS; j++) begin
            if (!found && (IDX_W'(j) >= op_idx) && in_array[j]) begin
                sel_idx = IDX_W'(j);
                found   = 1'b1;
            end
        end
    end

    step_t cur;
    assign cur      = script_step(sel_idx);
    assign sel_last = (sel_idx == LAST_STEP);
    assign is_write = cur.is_write;
    assign value    = cur.value ^ pass;

    always_comb begin
        case (cur.drow)
            OFS_DEC: tgt_row = cur_row - 1'b1;
            OFS_INC: tgt_row = cur_row + 1'b1;
            default: tgt_row = cur_row;
        endcase
        case (cur.dcol)
            OFS_DEC: tgt_col = cur_col - 1'b1;
            OFS_INC: tgt_col = cur_col + 1'b1;
            default: tgt_col = cur_col;
        endcase
    end

endmodule

// File: rtl/sd_read_check.sv
module sd_read_check #(
    parameter int unsigned RW = 4,
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          rd_issue,
    input  logic          rd_exp,
    input  logic [RW-1:0] rd_row,
    input  logic [CW-1:0] rd_col,
    input  logic          rd_pass,
    input  logic          rd_final,
    input  logic          mem_rdata,
    output logic          pending,
    output logic          done,
    output logic          fail,
    output logic          fail_pass,
    output logic [RW-1:0] fail_row,
    output logic [CW-1:0] fail_col
);

    typedef struct packed {
        logic          vld;
        logic          exp;
        logic          last;
        logic          pass;
        logic [RW-1:0] row;
        logic [CW-1:0] col;
    } pend_t;

    pend_t pend;
    logic  miss;

    assign pending = pend.vld;
    assign miss    = pend.vld & (mem_rdata != pend.exp);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend      <= '0;
            done      <= 1'b0;
            fail      <= 1'b0;
            fail_pass <= 1'b0;
            fail_row  <= '0;
            fail_col  <= '0;
        end else begin
            pend.vld  <= rd_issue;
            pend.exp  <= rd_exp;
            pend.last <= rd_issue & rd_final;
            pend.pass <= rd_pass;
            pend.row  <= rd_row;
            pend.col  <= rd_col;
            done      <= pend.vld & pend.last;
            if (clear) begin
                fail      <= 1'b0;
                fail_pass <= 1'b0;
                fail_row  <= '0;
                fail_col  <= '0;
            end else if (miss && !fail) begin
                fail      <= 1'b1;
                fail_pass <= pend.pass;
                fail_row  <= pend.row;
                fail_col  <= pend.col;
            end
        end
    end

endmodule

// File: rtl/sd_surround_test.sv
module sd_surround_test
    import sd_pkg::*;
#(
    parameter int unsigned ROWS = 16,
    parameter int unsigned COLS = 16,
    localparam int unsigned RW  = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int unsigned CW  = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic          done,
    output logic          fail,
    output logic          fail_pass,
    output logic [RW-1:0] fail_row,
    output logic [CW-1:0] fail_col,
    output logic          mem_en,
    output logic          mem_we,
    output logic [RW-1:0] mem_row,
    output logic [CW-1:0] mem_col,
    output logic          mem_wdata,
    input  logic          mem_rdata
);

    logic             running;
    logic             pass;
    logic [RW-1:0]    cur_row;
    logic [CW-1:0]    cur_col;
    logic [IDX_W-1:0] op_idx;
    logic [IDX_W-1:0] sel_idx;
    logic             sel_last;
    logic             final_op;
    logic             is_write;
    logic             value;
    logic             pending;
    logic             start_ok;

    assign start_ok = start & ~running & ~pending;

    sd_cursor #(.ROWS(ROWS), .COLS(COLS), .RW(RW), .CW(CW)) u_cursor (
        .clk      (clk),
        .rst      (rst),
        .start_ok (start_ok),
        .sel_idx  (sel_idx),
        .sel_last (sel_last),
        .running  (running),
        .pass     (pass),
        .cur_row  (cur_row),
        .cur_col  (cur_col),
        .op_idx   (op_idx),
        .final_op (final_op)
    );

    sd_step_picker #(.ROWS(ROWS), .COLS(COLS), .RW(RW), .CW(CW)) u_picker (
        .cur_row  (cur_row),
        .cur_col  (cur_col),
        .op_idx   (op_idx),
        .pass     (pass),
        .sel_idx  (sel_idx),
        .sel_last (sel_last),
        .tgt_row  (mem_row),
        .tgt_col  (mem_col),
        .is_write (is_write),
        .value    (value)
    );

    assign mem_en    = running;
    assign mem_we    = running & is_write;
    assign mem_wdata = value;

    sd_read_check #(.RW(RW), .CW(CW)) u_check (
        .clk       (clk),
        .rst       (rst),
        .clear     (start_ok),
        .rd_issue  (running & ~is_write),
        .rd_exp    (value),
        .rd_row    (mem_row),
        .rd_col    (mem_col),
        .rd_pass   (pass),
        .rd_final  (final_op),
        .mem_rdata (mem_rdata),
        .pending   (pending),
        .done      (done),
        .fail      (fail),
        .fail_pass (fail_pass),
        .fail_row  (fail_row),
        .fail_col  (fail_col)
    );

endmodule

// File: rtl/sd_surround_test_sva.sv
module sd_surround_test_sva #(
    parameter int unsigned ROWS = 16,
    parameter int unsigned COLS = 16,
    parameter int unsigned RW   = 4,
    parameter int unsigned CW   = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          done,
    input logic          fail,
    input logic          fail_pass,
    input logic [RW-1:0] fail_row,
    input logic [CW-1:0] fail_col,
    input logic          mem_en,
    input logic [RW-1:0] mem_row,
    input logic [CW-1:0] mem_col
);

    a_r11_addr_in_range: assert property (@(posedge clk) disable iff (rst)
        mem_en |-> ((mem_row <= RW'(ROWS - 1)) && (mem_col <= CW'(COLS - 1))));

    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r8_done_quiet: assert property (@(posedge clk) disable iff (rst)
        done |-> !mem_en);

    // the request stream never pauses inside a run, so a falling enable ends it
    a_r3_end_then_done: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_en) |=> done);

    a_r7_fail_sticky: assert property (@(posedge clk) disable iff (rst)
        (fail && !start) |=> fail);

    a_r7_capture_held: assert property (@(posedge clk) disable iff (rst)
        (fail && !start) |=> ($stable(fail_row) && $stable(fail_col) && $stable(fail_pass)));

endmodule

bind sd_surround_test sd_surround_test_sva #(
    .ROWS(ROWS), .COLS(COLS), .RW(RW), .CW(CW)
) u_sva (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .done      (done),
    .fail      (fail),
    .fail_pass (fail_pass),
    .fail_row  (fail_row),
    .fail_col  (fail_col),
    .mem_en    (mem_en),
    .mem_row   (mem_row),
    .mem_col   (mem_col)
);

// File: tb/sd_surround_test_tb.sv
`timescale 1ns/100ps
module sd_surround_test_tb;

    localparam int BR     = 4;
    localparam int BC     = 5;
    localparam int RW     = $clog2(BR);
    localparam int CW     = $clog2(BC);
    localparam int MAXOPS = 16 * BR * BC;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          done, fail, fail_pass;
    logic [RW-1:0] fail_row, mem_row;
    logic [CW-1:0] fail_col, mem_col;
    logic          mem_en, mem_we, mem_wdata;
    logic          mem_rdata = 1'b0;

    int vectors = 0;
    int misses  = 0;

    always #2.5 clk = ~clk;

    sd_surround_test #(.ROWS(BR), .COLS(BC)) u_dut (
        .clk(clk), .rst(rst), .start(start), .done(done), .fail(fail),
        .fail_pass(fail_pass), .fail_row(fail_row), .fail_col(fail_col),
        .mem_en(mem_en), .mem_we(mem_we), .mem_row(mem_row), .mem_col(mem_col),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // memory model with an optional fault: 0 none, 1 stuck-at, 2 coupling
    logic mem_arr [BR][BC];
    int   fault_kind = 0;
    int   f_r, f_c, f_v, ag_r, ag_c;

    task automatic put_bit(input int r, input int c, input logic v);
        if (fault_kind == 1 && r == f_r && c == f_c) begin
            mem_arr[r][c] = logic'(f_v[0]);
        end else begin
            mem_arr[r][c] = v;
            if (fault_kind == 2 && r == ag_r && c == ag_c) mem_arr[f_r][f_c] = v;
        end
    endtask

    task automatic fill_mem();
        for (int r = 0; r < BR; r++)
            for (int c = 0; c < BC; c++)
                mem_arr[r][c] = logic'((r + c) & 1);
        if (fault_kind == 1) mem_arr[f_r][f_c] = logic'(f_v[0]);
    endtask

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) put_bit(int'(mem_row), int'(mem_col), mem_wdata);
            else        mem_rdata <= mem_arr[mem_row][mem_col];
        end
    end

    task automatic chk(input string req, input int got, input int exp);
        vectors++;
        if (got !== exp) begin
            misses++;
            $display("FAIL %s got %0h expected %0h", req, got, exp);
        end
    endtask

    // expected operation stream and first failure
    logic ex_we  [MAXOPS];
    logic ex_val [MAXOPS];
    int   ex_row [MAXOPS];
    int   ex_col [MAXOPS];
    int   n_ex;
    bit   exp_fail;
    int   exp_fidx, exp_frow, exp_fcol, exp_fpass;

    task automatic build_ref();
        n_ex = 0;
        exp_fail = 0;
        fill_mem();
        for (int ps = 0; ps < 2; ps++)
            for (int p = 0; p < BR; p++)
                for (int q = 0; q < BC; q++)
                    for (int k = 0; k < 8; k++) begin
                        int r, c;
                        logic w, v;
                        r = p; c = q;
                        case (k)
                            0: begin w = 1; v = 0; c = q - 1; end
                            1: begin w = 1; v = 0; end
                            2: begin w = 1; v = 0; c = q + 1; end
                            3: begin w = 1; v = 1; r = p - 1; end
                            4: begin w = 0; v = 0; c = q + 1; end
                            5: begin w = 1; v = 1; r = p + 1; end
                            6: begin w = 0; v = 0; c = q - 1; end
                            default: begin w = 0; v = 0; end
                        endcase
                        v = v ^ logic'(ps[0]);
                        if (r >= 0 && r < BR && c >= 0 && c < BC) begin
                            ex_we[n_ex] = w; ex_val[n_ex] = v;
                            ex_row[n_ex] = r; ex_col[n_ex] = c;
                            if (w) put_bit(r, c, v);
                            else if (!exp_fail && mem_arr[r][c] != v) begin
                                exp_fail = 1; exp_fidx = n_ex;
                                exp_frow = r; exp_fcol = c; exp_fpass = ps;
                            end
                            n_ex++;
                        end
                    end
        fill_mem();
    endtask

    function automatic int pack_op(input logic en, input logic we, input int r,
                                   input int c, input logic wd);
        return (int'(en) << 20) | (int'(we) << 19) | (r << 10) | (c << 1) | int'(we & wd);
    endfunction

    task automatic run_test(input bit mid);
        build_ref();
        @(negedge clk);
        start = 1'b1;
        for (int c = 0; c < n_ex + 3; c++) begin
            @(negedge clk);
            if (c == 0) start = 1'b0;
            if (c < n_ex)
                // R2 R3 R4 R5 R11: exact stream, one operation per cycle, no gaps
                chk("R2/R3/R4/R5/R11 op", pack_op(mem_en, mem_we, int'(mem_row), int'(mem_col), mem_wdata),
                    pack_op(1'b1, ex_we[c], ex_row[c], ex_col[c], ex_val[c]));
            else
                chk("R3 idle after run", int'(mem_en), 0);
            chk("R8 done timing", int'(done), int'(c == n_ex + 1));
            if (c == 0) chk("R10 fail cleared", int'(fail), 0);
            else chk("R6 R7 fail timing", int'(fail), int'(exp_fail && c >= exp_fidx + 2));
            if (mid && c == 3) start = 1'b1;     // R9: must be ignored
            if (mid && c == 4) start = 1'b0;
        end
        if (exp_fail)
            chk("R7 capture", (int'(fail_row) << 8) | (int'(fail_col) << 1) | int'(fail_pass),
                (exp_frow << 8) | (exp_fcol << 1) | exp_fpass);
    endtask

    task automatic pick_random_fault();
        fault_kind = $urandom_range(0, 2);
        f_r = $urandom_range(0, BR - 1);
        f_c = $urandom_range(0, BC - 1);
        f_v = $urandom_range(0, 1);
        ag_c = f_c;
        ag_r = (f_r == 0) ? 1 : ((f_r == BR - 1) ? BR - 2 : f_r + (($urandom_range(0, 1) == 1) ? 1 : -1));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        misses++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk("R1 reset done", int'(done), 0);
        chk("R1 reset fail", int'(fail), 0);
        rst = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk("R1 idle no request", int'(mem_en), 0);
        end
        fault_kind = 0;                                   run_test(0);
        fault_kind = 1; f_r = 0; f_c = 0; f_v = 1;        run_test(0);
        fault_kind = 0;                                   run_test(0);  // R10 after failing run
        fault_kind = 2; f_r = 1; f_c = 2; ag_r = 0; ag_c = 2; run_test(0);
        fault_kind = 1; f_r = BR - 1; f_c = BC - 1; f_v = 0; run_test(0); // R5 inverted pass catch
        fault_kind = 2; f_r = BR - 1; f_c = 0; ag_r = BR - 2; ag_c = 0; run_test(1); // R9
        for (int i = 0; i < 8; i++) begin
            pick_random_fault();
            run_test(i == 3);
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule